// File: doc/BRIEF.md
# Radix-16 Quotient Digit Selector

This block picks the next quotient digit for a radix-16 digit-recurrence divider whose digits lie in the signed set −9..+9. The divider hands it a truncated estimate of the shifted partial remainder 16W. The block compares that estimate in parallel against nineteen midpoint constants, Mk = (k + 0.5)·D for k = −9..+9. It returns the digit whose interval holds the estimate. No lookup table is involved. The set's redundancy factor is 9/15 = 0.6, so the digit it picks keeps the next remainder inside ±0.6·D.

The constants are formed from the normalized divisor D in [1, 2) when a division starts (`load_div` high for one cycle). They are truncated to two fractional hex digits and kept in registers until the next load. The estimate path is purely combinational. Each comparison's sign is one bit of a thermometer vector. The bit count, less nine, is the digit. From the digit the block derives a magnitude that selects the divisor multiple, and a control that says whether that multiple is subtracted from or added to the remainder.

Top module: `qds_r16_sel`

## Requirements
- R1: After reset, and before any load, every constant is zero: the digit is +9 for a non-negative estimate and −9 for a negative one.
- R2: On a clock edge with `load_div` high, constant k is captured as floor(256·(k + 0.5)·D) in units of 2^-8, for k = −9..+9. The digit follows these constants from the next cycle, exactly at each interval boundary.
- R3: Within the same cycle as the estimate, the digit equals (number of constants with Mk ≤ estimate) − 9, with a count of 19 clamped to 18. An estimate equal to Mk therefore gives digit k+1, or +9 when k = 9.
- R4: For every estimate E on the 2^-8 grid with |E| ≤ 9.6·D, and D in [1, 2), the chosen digit q satisfies |E − q·D| ≤ 0.6·D.
- R5: `q_digit` is the digit in 5-bit two's complement (for example −9 is 10111b).
- R6: `mux_sel` is the unsigned magnitude |q| in 4 bits (0..9).
- R7: `add_sub` is 1 exactly when q > 0 (the multiple is subtracted). It is 0 for zero and negative digits.
- R8: Estimates beyond the outermost constants saturate: the most positive code gives +9 and the most negative gives −9.
- R9: A change of `divisor` while `load_div` is low has no effect on the constants or on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, clears the constants |
| load_div | input | 1 | Capture new constants from `divisor` at this edge |
| divisor | input | DFRAC+1 (13) | Normalized divisor, 1 integer bit and DFRAC fraction bits |
| rem_est | input | EINT+TFRAC (14) | Two's-complement truncated estimate of 16W, TFRAC fraction bits |
| q_digit | output | 5 | Selected signed digit, two's complement |
| mux_sel | output | 4 | Digit magnitude, selects the divisor multiple |
| add_sub | output | 1 | 1: subtract the multiple, 0: add it |

## Verification
The bench builds the block with its defaults: DFRAC = 12, TFRAC = 8, EINT = 6 and QMAX = 9. Dropping five divisor fraction bits makes floor truncation of the negative constants differ from plain chopping, so the off-by-one-ulp boundary estimates sit on those rounding decisions. The 14-bit estimate reaches past ±9.6·D for the largest divisor, which puts both saturation ends within reach. A full grid sweep for six divisors covers every interval and its ends, including the smallest and largest normalized divisors.

// File: rtl/qds_pkg.sv
package qds_pkg;
  // Operation applied to the selected divisor multiple.
  typedef enum logic {
    OP_ADD = 1'b0,
    OP_SUB = 1'b1
  } qds_op_e;

  // Bits per radix-16 digit; one fractional hex digit = 4 fraction bits.
  localparam int HEX_BITS = 4;
endpackage

// File: rtl/qds_const_gen.sv
module qds_const_gen #(
  parameter int DFRAC = 12,
  parameter int TFRAC = 8,
  parameter int CW    = 14,
  parameter int QMAX  = 9,
  localparam int NK   = 2 * QMAX + 1,
  localparam int SH   = DFRAC + 1 - TFRAC
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     load_i,
  input  logic [DFRAC:0]           divisor_i,
  output logic [NK-1:0][CW-1:0]    mk_o
);
  // floor((k + 0.5) * d) on a 2^-TFRAC grid: (2k+1)*d carries DFRAC+1
  // fraction bits, an arithmetic right shift floors to TFRAC bits.
  function automatic logic [CW-1:0] midpoint(input int k, input logic [DFRAC:0] d);
    longint prod;
    prod = longint'(2 * k + 1) * longint'(d);
    return CW'(prod >>> SH);
  endfunction

  logic [NK-1:0][CW-1:0] mk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mk_q <= '0;
    end else if (load_i) begin
      for (int i = 0; i < NK; i++) begin
        mk_q[i] <= midpoint(i - QMAX, divisor_i);
      end
    end
  end

  assign mk_o = mk_q;
endmodule

// File: rtl/qds_compare.sv
module qds_compare #(
  parameter int CW   = 14,
  parameter int QMAX = 9,
  localparam int NK  = 2 * QMAX + 1
) (
  input  logic [CW-1:0]          est_i,
  input  logic [NK-1:0][CW-1:0]  mk_i,
  output logic [NK-1:0]          ge_o
);
  // Each bit is the sign of (estimate - constant): 1 when non-negative.
  for (genvar i = 0; i < NK; i++) begin : g_cmp
    assign ge_o[i] = $signed(est_i) >= $signed(mk_i[i]);
  end
endmodule

// File: rtl/qds_encode.sv
module qds_encode
  import qds_pkg::*;
#(
  parameter int QMAX   = 9,
  localparam int NK    = 2 * QMAX + 1,
  localparam int CNT_W = $clog2(NK + 1),
  localparam int DIG_W = $clog2(QMAX + 1) + 1,
  localparam int SEL_W = DIG_W - 1
) (
  input  logic [NK-1:0]     ge_i,
  output logic [DIG_W-1:0]  digit_o,
  output logic [SEL_W-1:0]  mag_o,
  output qds_op_e           op_o
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cnt_sat;
  logic [DIG_W-1:0] digit;

  always_comb begin
    cnt = '0;
    for (int i = 0; i < NK; i++) begin
      cnt = cnt + CNT_W'(ge_i[i]);
    end
    cnt_sat = (cnt > CNT_W'(2 * QMAX)) ? CNT_W'(2 * QMAX) : cnt;
    digit   = DIG_W'(cnt_sat) - DIG_W'(QMAX);
  end

  assign digit_o = digit;
  assign mag_o   = digit[DIG_W-1] ? SEL_W'(-digit) : SEL_W'(digit);
  assign op_o    = (!digit[DIG_W-1] && (digit != '0)) ? OP_SUB : OP_ADD;
endmodule

// File: rtl/qds_r16_sel.sv
module qds_r16_sel
  import qds_pkg::*;
#(
  parameter int DFRAC  = 12,
  parameter int TFRAC  = 2 * HEX_BITS,
  parameter int EINT   = 6,
  parameter int QMAX   = 9,
  localparam int EW    = EINT + TFRAC,
  localparam int NK    = 2 * QMAX + 1,
  localparam int DIG_W = $clog2(QMAX + 1) + 1,
  localparam int SEL_W = DIG_W - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_div,
  input  logic [DFRAC:0]    divisor,
  input  logic [EW-1:0]     rem_est,
  output logic [DIG_W-1:0]  q_digit,
  output logic [SEL_W-1:0]  mux_sel,
  output logic              add_sub
);
  logic [NK-1:0][EW-1:0] mk_tab;
  logic [NK-1:0]         ge_vec;
  qds_op_e               op_sel;

  qds_const_gen #(.DFRAC(DFRAC), .TFRAC(TFRAC), .CW(EW), .QMAX(QMAX)) u_const (
    .clk(clk), .rst_n(rst_n), .load_i(load_div), .divisor_i(divisor), .mk_o(mk_tab)
  );

  qds_compare #(.CW(EW), .QMAX(QMAX)) u_cmp (
    .est_i(rem_est), .mk_i(mk_tab), .ge_o(ge_vec)
  );

  qds_encode #(.QMAX(QMAX)) u_enc (
    .ge_i(ge_vec), .digit_o(q_digit), .mag_o(mux_sel), .op_o(op_sel)
  );

  assign add_sub = op_sel;

  // R2: constants only move on a load edge.
  a_r2_const_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !load_div |=> $stable(mk_tab));

  // R3: the comparison signs form a thermometer from the lowest constant up.
  a_r3_thermometer: assert property (@(posedge clk) disable iff (!rst_n)
    ((ge_vec + NK'(1)) & ge_vec) == '0);

  // R5: the digit stays inside the signed digit set.
  a_r5_digit_range: assert property (@(posedge clk) disable iff (!rst_n)
    ($signed(q_digit) >= -QMAX) && ($signed(q_digit) <= QMAX));

  // R6: the select code is a magnitude in range, zero only for a zero digit.
  a_r6_sel_range: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(mux_sel) <= QMAX) && ((mux_sel == '0) == (q_digit == '0)));

  // R7: subtract control agrees with the digit sign.
  a_r7_op_sign: assert property (@(posedge clk) disable iff (!rst_n)
    add_sub == ($signed(q_digit) > 0));

  // R9: without a load, a steady estimate keeps a steady digit.
  a_r9_no_load_no_change: assert property (@(posedge clk) disable iff (!rst_n)
    !load_div |=> (!$stable(rem_est) || $stable(q_digit)));
endmodule

// File: tb/qds_r16_sel_bench.sv
`timescale 1ns/1ps
module qds_r16_sel_bench;
  localparam int DFRAC = 12;
  localparam int EW    = 14;
  localparam int DIG_W = 5;
  localparam real ULP  = 256.0;

  typedef struct packed {
    int est;
    int exp_q;
    int dint;
    int tag;
    logic conv;
  } item_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic load_div = 1'b0;
  logic [DFRAC:0] divisor = '0;
  logic [EW-1:0] rem_est = '0;
  logic [DIG_W-1:0] q_digit;
  logic [DIG_W-2:0] mux_sel;
  logic add_sub;

  int n_tests = 0;
  int n_fail = 0;
  item_t sb_q[$];
  bit all_done = 1'b0;

  always #10 clk = ~clk;

  qds_r16_sel u_qds_r16_sel (
    .clk(clk), .rst_n(rst_n), .load_div(load_div), .divisor(divisor),
    .rem_est(rem_est), .q_digit(q_digit), .mux_sel(mux_sel), .add_sub(add_sub)
  );

  // Reference digit from real arithmetic; dint = 0 models reset constants.
  function automatic int ref_digit(input int est, input int dint);
    int cnt = 0;
    real d = real'(dint) / 4096.0;
    for (int k = -9; k <= 9; k++) begin
      if (real'(est) >= $floor((real'(k) + 0.5) * d * ULP)) cnt++;
    end
    if (cnt > 18) cnt = 18;
    return cnt - 9;
  endfunction

  function automatic int ref_const(input int k, input int dint);
    return int'($floor((real'(k) + 0.5) * (real'(dint) / 4096.0) * ULP));
  endfunction

  task automatic check(input bit ok, input int tag, input int act, input int exp_v);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL R%0d: actual %0d expected %0d", tag, act, exp_v);
    end
  endtask

  task automatic do_load(input int dint);
    @(posedge clk); #1;
    load_div = 1'b1;
    divisor  = (DFRAC+1)'(dint);
    @(posedge clk); #1;
    load_div = 1'b0;
  endtask

  // Driver: apply an estimate and push what the bench expects for it.
  task automatic drive(input int est, input int model_d, input int tag, input logic conv);
    item_t it;
    @(posedge clk); #1;
    rem_est  = EW'(est);
    it.est   = est;
    it.exp_q = ref_digit(est, model_d);
    it.dint  = model_d;
    it.tag   = tag;
    it.conv  = conv;
    sb_q.push_back(it);
  endtask

  // Monitor: pop and compare away from the active edge.
  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      item_t it;
      int q_act, mag;
      real d, e;
      it = sb_q.pop_front();
      q_act = int'($signed(q_digit));
      check(q_act == it.exp_q, it.tag, q_act, it.exp_q);
      // R5: raw bit pattern is the 5-bit two's complement of the digit
      check(int'(q_digit) == ((it.exp_q + 32) % 32), 5, int'(q_digit), (it.exp_q + 32) % 32);
      mag = (it.exp_q < 0) ? -it.exp_q : it.exp_q;
      check(int'(mux_sel) == mag, 6, int'(mux_sel), mag);   // R6
      check(int'(add_sub) == int'(it.exp_q > 0), 7, int'(add_sub), int'(it.exp_q > 0)); // R7
      if (it.conv) begin
        // R4: next remainder bound
        d = real'(it.dint) / 4096.0;
        e = real'(it.est) / ULP - real'(q_act) * d;
        if (e < 0.0) e = -e;
        check(e <= 0.6 * d, 4, q_act, it.exp_q);
      end
    end
  end

  int dlist[6] = '{4096, 4097, 5120, 6144, 7168, 8191};

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1: reset constants are zero
    drive(0, 0, 1, 1'b0);
    drive(-1, 0, 1, 1'b0);
    drive(255, 0, 1, 1'b0);
    // R8: saturation at both ends of the code range
    do_load(4096);
    drive(8191, 4096, 8, 1'b0);
    drive(-8192, 4096, 8, 1'b0);
    // R9: divisor moves with load low, constants stay from 1.5
    do_load(6144);
    @(posedge clk); #1 divisor = 13'd8191;
    for (int k = -9; k <= 9; k++) begin
      drive(ref_const(k, 6144), 6144, 9, 1'b0);
      drive(ref_const(k, 6144) - 1, 6144, 9, 1'b0);
    end
    foreach (dlist[i]) begin
      int lim;
      do_load(dlist[i]);
      // R2: exact boundaries right after the load
      for (int k = -9; k <= 9; k++) begin
        drive(ref_const(k, dlist[i]), dlist[i], 2, 1'b0);
        drive(ref_const(k, dlist[i]) - 1, dlist[i], 2, 1'b0);
      end
      // R3 and R4: full grid sweep inside +-9.6 D
      lim = int'($floor(9.6 * (real'(dlist[i]) / 4096.0) * ULP));
      for (int e = -lim; e <= lim; e++) drive(e, dlist[i], 3, 1'b1);
    end
    @(posedge clk);
    @(posedge clk);
    all_done = 1'b1;
  end

  initial begin
    wait (all_done && sb_q.size() == 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule